// File: doc/BRIEF.md
# Four-Output Reference Clock Divider

This block produces four clock-like outputs from a single reference clock. Every output has its own 8-bit divide value, a phase offset chosen from four quarter-period steps, a duty mode, and an enable bit. The whole setting lives in one 49-bit word. The word is pushed in serially, one bit per reference cycle, and takes effect only when a load strobe is applied. A lock flag tells downstream logic when every enabled output has run through at least one complete division period.

Everything runs on the reference clock, and the outputs are plain registered signals. The block contains no analog circuitry, does not switch clocks glitch-free, and does not retime to any other domain. It is typically placed first in a long serial configuration path. The serial output feeds the next stage of that path.

Top module: `refclk_divider_bank`

## Requirements
- R1: On every reference clock edge the shift register takes `cfg_in` into its top bit (bit 48) and moves every other bit down by one. `cfg_out` always shows bit 0. A bit that enters is therefore seen on `cfg_out` after 49 edges.
- R2: The active setting changes only on an edge where `cfg_load` is high, and it then takes the shift register contents from before that edge. Shifting without a load leaves every output and `locked` unaffected.
- R3: Setting word layout:
  - bit 0 is the global enable.
  - Bits [8n+8:8n+1] hold the divide value D of output n.
  - Bits [34+2n:33+2n] hold the phase code of output n.
  - Bit 41+n enables output n.
  - Bit 45+n selects the duty mode of output n (1 = square wave, 0 = pulse).
- R4: An enabled output has a counter that runs 0..D and wraps, so its pattern repeats every D+1 reference cycles. After a load edge (count k=0), edge k sees counter value (k-1) mod (D+1).
- R5: The phase offset P is 0, D/4, D/2 or D/2+D/4 (integer division) for codes 0, 1, 2 and 3. The first high cycle after a load is at edge P+1.
- R6: In pulse mode the output is high for exactly one reference cycle per period. That cycle is the one that follows the counter value P.
- R7: In square-wave mode the output toggles after counter value P and again after counter value (P + (D+1)/2) mod (D+1). It starts low after a load.
- R8: With D=0, pulse mode keeps the output high on every cycle after the first edge, and square-wave mode toggles it on every cycle.
- R9: When the global enable or an output's own enable is low, that output is held low and its counter is held at zero.
- R10: `locked` is high when the global enable is set and every enabled output has completed one full period. For the slowest enabled output this happens from edge D+1 after the load. Disabled outputs count as complete. `locked` is low whenever the global enable is low.
- R11: A load edge restarts all counters from zero and clears the completion state. After a load that enables any output, `locked` is therefore low.
- R12: Reset clears the shift register and the active setting. All outputs, `cfg_out` and `locked` are then low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_in | input | 1 | Serial setting data, entering at the top of the shift register |
| cfg_load | input | 1 | Transfers the shift register into the active setting |
| cfg_out | output | 1 | Bit 0 of the shift register, for the next stage in the path |
| div_out | output | 4 | Divided outputs, bit n is output n |
| locked | output | 1 | All enabled outputs have completed a period |

## Verification
A load strobe can land on the same edge at which an output finishes its first period. In that case the restart must win: `locked` must not rise, and the counter must begin again from zero. The bench arranges this on purpose. It loads a setting with D=60 and waits eleven cycles. It then shifts the same word in again, so that the second load falls on exactly the edge where the first period would complete. The bench then expects `locked` to stay low through edge 60 of the new run, to rise at edge 61, and the first pulse to appear at edge 1.

// File: rtl/refclk_divider_bank.sv
module refclk_divider_bank #(
  parameter int NOUT = 4,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_in,
  input  logic            cfg_load,
  output logic            cfg_out,
  output logic [NOUT-1:0] div_out,
  output logic            locked
);
  localparam int DIV_LO  = 1;
  localparam int PH_LO   = DIV_LO + NOUT * DW;
  localparam int EN_LO   = PH_LO + 2 * NOUT;
  localparam int DUTY_LO = EN_LO + NOUT;
  localparam int CFG_W   = DUTY_LO + NOUT;
  localparam logic [DW-1:0] ONE  = {{(DW-1){1'b0}}, 1'b1};
  localparam logic [DW:0]   ONEW = {{DW{1'b0}}, 1'b1};

  logic [CFG_W-1:0] shift_q, act_q;
  logic             glb_en;
  logic [NOUT-1:0]  run, done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q <= '0;
      act_q   <= '0;
    end else begin
      shift_q <= {cfg_in, shift_q[CFG_W-1:1]};
      if (cfg_load) act_q <= shift_q;
    end
  end

  assign cfg_out = shift_q[0];
  assign glb_en  = act_q[0];
  assign locked  = glb_en & (&(done_q | ~run));

  AST_SHIFT_IN:  assert property (@(posedge clk) disable iff (!rst_n)
                   1'b1 |=> shift_q[CFG_W-1] == $past(cfg_in));                // R1
  AST_HOLD_CFG:  assert property (@(posedge clk) disable iff (!rst_n)
                   !cfg_load |=> $stable(act_q));                              // R2
  AST_LOAD_UNLK: assert property (@(posedge clk) disable iff (!rst_n)
                   (cfg_load && shift_q[0] && |shift_q[EN_LO +: NOUT]) |=> !locked); // R11
  AST_LOCK_GLB:  assert property (@(posedge clk) disable iff (!rst_n)
                   locked |-> glb_en);                                         // R10

  for (genvar g = 0; g < NOUT; g++) begin : g_out
    logic [DW-1:0] lim, off, cnt_q, tog_pt;
    logic [DW:0]   n_full, half, sum;
    logic [1:0]    ph;
    logic          duty, out_q, done_l, at_off, at_tog, at_end;

    assign lim    = act_q[DIV_LO + g*DW +: DW];
    assign ph     = act_q[PH_LO + 2*g +: 2];
    assign duty   = act_q[DUTY_LO + g];
    assign run[g] = glb_en & act_q[EN_LO + g];

    always_comb begin
      case (ph)
        2'd0:    off = '0;
        2'd1:    off = lim >> 2;
        2'd2:    off = lim >> 1;
        default: off = (lim >> 1) + (lim >> 2);
      endcase
    end

    assign n_full = {1'b0, lim} + ONEW;
    assign half   = n_full >> 1;
    assign sum    = {1'b0, off} + half;
    assign tog_pt = (sum > {1'b0, lim}) ? DW'(sum - n_full) : sum[DW-1:0];

    assign at_off = (cnt_q == off);
    assign at_tog = (cnt_q == tog_pt);
    assign at_end = (cnt_q == lim);

    always_ff @(posedge clk) begin
      if (!rst_n || cfg_load || !run[g]) begin
        cnt_q  <= '0;
        out_q  <= 1'b0;
        done_l <= 1'b0;
      end else begin
        cnt_q <= at_end ? '0 : cnt_q + ONE;
        if (at_end) done_l <= 1'b1;
        out_q <= duty ? (out_q ^ (at_off | at_tog)) : at_off;
      end
    end

    assign div_out[g] = out_q;
    assign done_q[g]  = done_l;

    AST_CNT_RANGE:   assert property (@(posedge clk) disable iff (!rst_n)
                       cnt_q <= lim);                                          // R4
    AST_PULSE_ONE:   assert property (@(posedge clk) disable iff (!rst_n)
                       (run[g] && !duty && lim != '0 && div_out[g]) |=> !div_out[g]); // R6
    AST_IDLE_LOW:    assert property (@(posedge clk) disable iff (!rst_n)
                       !run[g] |-> !div_out[g]);                               // R9
    AST_D0_TOGGLE:   assert property (@(posedge clk) disable iff (!rst_n)
                       (run[g] && duty && lim == '0 && !cfg_load) |=> div_out[g] != $past(div_out[g])); // R8
  end
endmodule

// File: tb/refclk_divider_bank_tb.sv
module refclk_divider_bank_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_in = 1'b0;
  logic cfg_load = 1'b0;
  logic cfg_out, locked;
  logic [3:0] div_out;
  int nchk = 0;
  int nerr = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  refclk_divider_bank dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_in(cfg_in), .cfg_load(cfg_load),
    .cfg_out(cfg_out), .div_out(div_out), .locked(locked)
  );

  // idx, D, phase code, duty, expected first high edge, expected highs in edges 1..24
  localparam int TBL [0:8][0:5] = '{
    '{0, 3, 0, 0, 1, 6},
    '{1, 7, 1, 0, 2, 3},
    '{2, 9, 2, 0, 5, 2},
    '{3, 7, 3, 0, 5, 3},
    '{0, 0, 0, 0, 1, 24},
    '{1, 3, 0, 1, 1, 12},
    '{2, 0, 0, 1, 1, 12},
    '{3, 4, 2, 1, 3, 10},
    '{0, 5, 1, 1, 2, 12}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic shift_word(input logic [48:0] w);
    for (int i = 0; i < 49; i++) begin
      cfg_in = w[i];
      tick();
    end
    cfg_in = 1'b0;
  endtask

  task automatic do_load();
    cfg_load = 1'b1;
    tick();
    cfg_load = 1'b0;
  endtask

  // R3 field positions
  function automatic logic [48:0] mkw(input int idx, input int d, input int ph, input bit duty);
    logic [48:0] w = '0;
    w[8*idx + 1 +: 8] = 8'(d);
    w[33 + 2*idx +: 2] = 2'(ph);
    w[41 + idx] = 1'b1;
    w[45 + idx] = duty;
    return w;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    nchk++;
    nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [48:0] w;
    int first, cnt, bad, bad2;
    repeat (4) tick();
    rst_n = 1'b1;
    tick();
    chk(div_out == 4'b0 && !locked && !cfg_out, "R12", {div_out, locked, cfg_out}, 0);

    // R1 readback through cfg_out
    w = 49'h1_2345_6789_ABCD ^ 49'h0_F0F0_0F0F_5A5A;
    shift_word(w);
    bad = 0;
    for (int i = 0; i < 49; i++) begin
      if (cfg_out != w[i]) bad++;
      tick();
    end
    chk(bad == 0, "R1", bad, 0);
    chk(div_out == 4'b0 && !locked, "R2 no load", div_out, 0);

    // table walk: one output enabled per entry
    for (int e = 0; e < 9; e++) begin
      int idx, d;
      string rq;
      idx = TBL[e][0];
      d = TBL[e][1];
      w = mkw(idx, d, TBL[e][2], TBL[e][3] != 0) | 49'd1;
      shift_word(w);
      do_load();
      chk(!locked && div_out == 4'b0, "R11 after load", {locked, div_out}, 0);
      first = 0; cnt = 0; bad = 0; bad2 = 0;
      for (int k = 1; k <= 24; k++) begin
        tick();
        if (div_out[idx]) begin
          cnt++;
          if (first == 0) first = k;
        end
        if (locked != (k >= d + 1)) bad++;
        if ((div_out & ~(4'b1 << idx)) != 4'b0) bad2++;
      end
      rq = (d == 0) ? "R8" : (TBL[e][3] != 0 ? "R7" : "R6");
      chk(first == TBL[e][4], "R5 first high", first, TBL[e][4]);
      chk(cnt == TBL[e][5], rq, cnt, TBL[e][5]);
      chk(bad == 0, "R10 lock timing", bad, 0);
      chk(bad2 == 0, "R9 disabled outputs low", bad2, 0);
    end

    // R4 long period, D=255 phase 3 on output 1: offset 190
    w = mkw(1, 255, 3, 1'b0) | 49'd1;
    shift_word(w);
    do_load();
    first = 0; cnt = 0; bad = 0;
    for (int k = 1; k <= 512; k++) begin
      tick();
      if (div_out[1]) begin
        cnt++;
        if (first == 0) first = k;
      end
      if (locked != (k >= 256)) bad++;
    end
    chk(first == 191 && cnt == 2, "R4 D=255", first * 10 + cnt, 1912);
    chk(bad == 0, "R10 D=255 lock", bad, 0);
    shift_word(w);
    chk(locked, "R10 held", locked, 1);
    do_load();
    chk(!locked, "R11 reload drops lock", locked, 0);
    first = 0;
    for (int k = 1; k <= 200; k++) begin
      tick();
      if (div_out[1] && first == 0) first = k;
    end
    chk(first == 191, "R11 restart", first, 191);

    // R2: D=0 pulse stays high while another word shifts in without load
    w = mkw(0, 0, 0, 1'b0) | 49'd1;
    shift_word(w);
    do_load();
    tick();
    bad = 0;
    for (int i = 0; i < 49; i++) begin
      cfg_in = 1'b1;
      tick();
      if (div_out != 4'b0001 || !locked) bad++;
    end
    cfg_in = 1'b0;
    chk(bad == 0, "R2", bad, 0);

    // R9 global enable low
    w = mkw(0, 0, 0, 1'b0) | mkw(1, 0, 0, 1'b0) | mkw(2, 0, 0, 1'b0) | mkw(3, 0, 0, 1'b0);
    shift_word(w);
    do_load();
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      tick();
      if (div_out != 4'b0 || locked) bad++;
    end
    chk(bad == 0, "R9 global off", bad, 0);

    // R9 single output disabled
    w = w | 49'd1;
    w[43] = 1'b0;
    shift_word(w);
    do_load();
    repeat (5) tick();
    chk(div_out == 4'b1011, "R9 one off", div_out, 4'b1011);

    // R10 two outputs: slowest decides
    w = mkw(0, 2, 0, 1'b0) | mkw(1, 9, 0, 1'b0) | 49'd1;
    shift_word(w);
    do_load();
    repeat (9) tick();
    chk(!locked, "R10 before slowest", locked, 0);
    tick();
    chk(locked, "R10 at slowest", locked, 1);

    // load coinciding with end of first period (D=60)
    w = mkw(0, 60, 0, 1'b0) | 49'd1;
    shift_word(w);
    do_load();
    repeat (11) tick();
    shift_word(w);
    chk(!locked, "R10 before period end", locked, 0);
    do_load();
    chk(!locked, "R11 load wins over completion", locked, 0);
    first = 0; bad = 0;
    for (int k = 1; k <= 61; k++) begin
      tick();
      if (div_out[0] && first == 0) first = k;
      if (locked != (k >= 61)) bad++;
    end
    chk(first == 1, "R11 restart first pulse", first, 1);
    chk(bad == 0, "R11 lock after restart", bad, 0);

    finish_run();
  end
endmodule